// File: doc/BRIEF.md
# Software-Refilled Address Translation Buffer

This block sits on a processor's memory-access path in front of on-chip shared memory. Addresses inside the 256 KiB on-chip window go straight through. Addresses at or above that window are treated as external virtual addresses. A small fully associative table maps each one, by 512-byte page, onto an on-chip physical page. The table has eight entries. Lookup is combinational, so the hit or miss and the translated address appear in the same cycle as the request.

On a miss, the block raises a registered trap that points execution at a fixed handler address. It also captures the faulting virtual address, the program counter and the access kind, so the handler can refill the table and then reissue the same instruction. Hardware never walks a page table. Software loads entries through a write port, choosing either an explicit slot or the next round-robin victim. Software can also clear the whole table in one cycle. While a trap is outstanding, the block ignores all further lookups until software acknowledges the trap.

Top module: `xlat_buf`

## Requirements
- R1: An active lookup whose address is below 0x40000 (upper 14 bits zero) asserts `xl_hit` in the same cycle, with `xl_paddr` equal to `lk_vaddr`.
- R2: `lk_kind` uses 0 = no memory access, 1 = instruction fetch, 2 = shared read and 3 = shared write. A cycle with `lk_valid` low or `lk_kind` 0 asserts neither `xl_hit` nor `xl_miss`.
- R3: An active lookup at or above 0x40000 hits in the same cycle when a valid entry's page number equals `lk_vaddr[31:9]`. `xl_paddr` is then 14 zero bits, followed by the entry's 9-bit physical page, followed by `lk_vaddr[8:0]`.
- R4: An active external lookup that matches no valid entry asserts `xl_miss` in that cycle. `trap_pending` rises on the next cycle, and `trap_vector` then reads the handler address 0x100 (zero otherwise).
- R5: On the cycle `trap_pending` rises, `trap_vaddr`, `trap_pc` and `trap_kind` hold the address, PC and kind of the missing access.
- R6: `trap_pending` and the captured fields hold until `trap_ack` is sampled high. The trap is then clear on the next cycle.
- R7: While `trap_pending` is high, lookups produce neither hit nor miss and leave the captured fields unchanged.
- R8: A write with `sw_we` high and `sw_use_victim` low loads slot `sw_index` with `sw_vpn`/`sw_ppn`. Lookups see the new entry from the next cycle.
- R9: A write with `sw_use_victim` high fills the victim slot. The victim starts at 0 after reset or invalidate-all, advances by one on each such write that is not merged by R10, and wraps from 7 to 0.
- R10: A write whose `sw_vpn` equals a valid entry's page number overwrites that entry, whatever slot was selected. The victim pointer does not move, so no two entries ever match the same page.
- R11: `sw_inval_all` clears every entry in one cycle and resets the victim to slot 0. A write in the same cycle is dropped.
- R12: After reset, no trap is pending and every external lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request present |
| lk_kind | input | 2 | Access kind (R2 encoding) |
| lk_vaddr | input | 32 | Address presented for lookup |
| lk_pc | input | 32 | PC of the issuing instruction |
| xl_paddr | output | 32 | Translated or forwarded address |
| xl_hit | output | 1 | Lookup resolved this cycle |
| xl_miss | output | 1 | External lookup missed this cycle |
| trap_pending | output | 1 | Trap outstanding |
| trap_vector | output | 32 | Handler address while a trap is outstanding |
| trap_vaddr | output | 32 | Captured faulting address |
| trap_pc | output | 32 | Captured faulting PC |
| trap_kind | output | 2 | Captured access kind |
| trap_ack | input | 1 | Software acknowledge of the trap |
| sw_we | input | 1 | Entry write strobe |
| sw_use_victim | input | 1 | Select the round-robin victim instead of `sw_index` |
| sw_index | input | 3 | Explicit slot for a write |
| sw_vpn | input | 23 | Virtual page number to load |
| sw_ppn | input | 9 | Physical page number to load |
| sw_inval_all | input | 1 | Clear every entry |

## Verification
The bench probes both sides of the 0x40000 boundary. A design with an off-by-one window would translate 0x3FFFF or forward 0x40000 untouched. It fills all eight slots and sweeps page offsets 0 and 511 in every slot, which catches a mis-sliced offset or physical page. It checks that lookups issued while a trap is outstanding neither resolve nor overwrite the captured PC. A design that re-arms would lose the restart point. It also runs the victim past a wrap and then writes a page that is already mapped, to catch a duplicate entry, a wrongly advanced victim or a victim that fails to reset on invalidate-all.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_FETCH = 2'd1,
    ACC_READ  = 2'd2,
    ACC_WRITE = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/xlat_cam.sv
module xlat_cam #(
  parameter int N     = 8,
  parameter int VPN_W = 23,
  parameter int PPN_W = 9,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] look_vpn,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_slot,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic             clr_all,
  output logic [N-1:0]     match_vec,
  output logic [PPN_W-1:0] hit_ppn,
  output logic             dup_any,
  output logic [IDX_W-1:0] dup_idx,
  output logic [N-1:0]     valid_vec
);
  logic [N-1:0]     dup_vec;
  logic [PPN_W-1:0] ppn_arr [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic             vld_q;
    logic [VPN_W-1:0] vpn_q;
    logic [PPN_W-1:0] ppn_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        vpn_q <= '0;
        ppn_q <= '0;
      end else if (clr_all) begin
        vld_q <= 1'b0;
      end else if (wr_en && wr_slot == IDX_W'(g)) begin
        vld_q <= 1'b1;
        vpn_q <= wr_vpn;
        ppn_q <= wr_ppn;
      end
    end
    assign valid_vec[g] = vld_q;
    assign match_vec[g] = vld_q && (vpn_q == look_vpn);
    assign dup_vec[g]   = vld_q && (vpn_q == wr_vpn);
    assign ppn_arr[g]   = ppn_q;
  end

  always_comb begin
    hit_ppn = '0;
    dup_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (match_vec[i]) hit_ppn = hit_ppn | ppn_arr[i];
      if (dup_vec[i])   dup_idx = IDX_W'(i);
    end
  end
  assign dup_any = |dup_vec;
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic             clear,
  output logic [IDX_W-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr <= '0;
    else if (clear)   ptr <= '0;
    else if (advance) ptr <= ptr + IDX_W'(1);
  end
endmodule

// File: rtl/xlat_trap.sv
module xlat_trap #(
  parameter int VA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            raise,
  input  logic            ack,
  input  logic [VA_W-1:0] in_vaddr,
  input  logic [VA_W-1:0] in_pc,
  input  logic [1:0]      in_kind,
  output logic            pending,
  output logic [VA_W-1:0] f_vaddr,
  output logic [VA_W-1:0] f_pc,
  output logic [1:0]      f_kind
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      f_vaddr <= '0;
      f_pc    <= '0;
      f_kind  <= '0;
    end else if (pending) begin
      if (ack) pending <= 1'b0;
    end else if (raise) begin
      pending <= 1'b1;
      f_vaddr <= in_vaddr;
      f_pc    <= in_pc;
      f_kind  <= in_kind;
    end
  end
endmodule

// File: rtl/xlat_buf.sv
module xlat_buf #(
  parameter int          VA_W       = 32,
  parameter int          PA_W       = 18,
  parameter int          PAGE_W     = 9,
  parameter int          ENTRIES    = 8,
  parameter logic [31:0] HANDLER_PC = 32'h0000_0100,
  localparam int VPN_W = VA_W - PAGE_W,
  localparam int PPN_W = PA_W - PAGE_W,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [1:0]       lk_kind,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic [VA_W-1:0]  lk_pc,
  output logic [VA_W-1:0]  xl_paddr,
  output logic             xl_hit,
  output logic             xl_miss,
  output logic             trap_pending,
  output logic [VA_W-1:0]  trap_vector,
  output logic [VA_W-1:0]  trap_vaddr,
  output logic [VA_W-1:0]  trap_pc,
  output logic [1:0]       trap_kind,
  input  logic             trap_ack,
  input  logic             sw_we,
  input  logic             sw_use_victim,
  input  logic [IDX_W-1:0] sw_index,
  input  logic [VPN_W-1:0] sw_vpn,
  input  logic [PPN_W-1:0] sw_ppn,
  input  logic             sw_inval_all
);
  import xlat_pkg::*;

  function automatic logic is_external(input logic [VA_W-1:0] va);
    return |va[VA_W-1:PA_W];
  endfunction

  function automatic logic [VA_W-1:0] compose_pa(input logic [PPN_W-1:0] ppn,
                                                 input logic [VA_W-1:0]  va);
    return {{(VA_W-PA_W){1'b0}}, ppn, va[PAGE_W-1:0]};
  endfunction

  // Named internal events, visible to the bound checker
  logic               lookup_live;
  logic               ext_addr;
  logic [ENTRIES-1:0] match_vec;
  logic [ENTRIES-1:0] entry_valid;
  logic [PPN_W-1:0]   hit_ppn;
  logic               dup_any;
  logic [IDX_W-1:0]   dup_idx;
  logic [IDX_W-1:0]   victim;
  logic [IDX_W-1:0]   wr_slot;
  logic               wr_go;
  logic               victim_step;

  assign lookup_live = lk_valid && (lk_kind != ACC_NONE) && !trap_pending;
  assign ext_addr    = is_external(lk_vaddr);
  assign xl_hit      = lookup_live && (!ext_addr || |match_vec);
  assign xl_miss     = lookup_live && ext_addr && !(|match_vec);
  assign xl_paddr    = ext_addr ? compose_pa(hit_ppn, lk_vaddr) : lk_vaddr;

  assign wr_go       = sw_we && !sw_inval_all;
  assign wr_slot     = dup_any ? dup_idx : (sw_use_victim ? victim : sw_index);
  assign victim_step = wr_go && sw_use_victim && !dup_any;
  assign trap_vector = trap_pending ? HANDLER_PC : '0;

  xlat_cam #(.N(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_cam (
    .clk       (clk),
    .rst_n     (rst_n),
    .look_vpn  (lk_vaddr[VA_W-1:PAGE_W]),
    .wr_en     (wr_go),
    .wr_slot   (wr_slot),
    .wr_vpn    (sw_vpn),
    .wr_ppn    (sw_ppn),
    .clr_all   (sw_inval_all),
    .match_vec (match_vec),
    .hit_ppn   (hit_ppn),
    .dup_any   (dup_any),
    .dup_idx   (dup_idx),
    .valid_vec (entry_valid)
  );

  xlat_victim #(.IDX_W(IDX_W)) u_victim (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (victim_step),
    .clear   (sw_inval_all),
    .ptr     (victim)
  );

  xlat_trap #(.VA_W(VA_W)) u_trap (
    .clk      (clk),
    .rst_n    (rst_n),
    .raise    (xl_miss),
    .ack      (trap_ack),
    .in_vaddr (lk_vaddr),
    .in_pc    (lk_pc),
    .in_kind  (lk_kind),
    .pending  (trap_pending),
    .f_vaddr  (trap_vaddr),
    .f_pc     (trap_pc),
    .f_kind   (trap_kind)
  );
endmodule

// File: rtl/xlat_buf_chk.sv
module xlat_buf_chk #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 18,
  parameter int ENTRIES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic [1:0]         lk_kind,
  input logic [VA_W-1:0]    lk_vaddr,
  input logic [VA_W-1:0]    lk_pc,
  input logic [VA_W-1:0]    xl_paddr,
  input logic               xl_hit,
  input logic               xl_miss,
  input logic               trap_pending,
  input logic [VA_W-1:0]    trap_vaddr,
  input logic [VA_W-1:0]    trap_pc,
  input logic               trap_ack,
  input logic               sw_inval_all,
  input logic [ENTRIES-1:0] entry_valid,
  input logic [ENTRIES-1:0] match_vec
);
  a_r1_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_kind != 2'd0 && !trap_pending && lk_vaddr[VA_W-1:PA_W] == '0)
      |-> (xl_hit && xl_paddr == lk_vaddr));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!lk_valid || lk_kind == 2'd0) |-> (!xl_hit && !xl_miss));

  a_r4_miss_traps: assert property (@(posedge clk) disable iff (!rst_n)
    xl_miss |=> trap_pending);

  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
    xl_miss |=> (trap_vaddr == $past(lk_vaddr) && trap_pc == $past(lk_pc)));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_pending && !trap_ack)
      |=> (trap_pending && $stable(trap_vaddr) && $stable(trap_pc)));

  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_pending && trap_ack) |=> !trap_pending);

  a_r7_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pending |-> (!xl_hit && !xl_miss));

  a_r10_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  a_r11_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    sw_inval_all |=> (entry_valid == '0));
endmodule

bind xlat_buf xlat_buf_chk #(.VA_W(VA_W), .PA_W(PA_W), .ENTRIES(ENTRIES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lk_valid     (lk_valid),
  .lk_kind      (lk_kind),
  .lk_vaddr     (lk_vaddr),
  .lk_pc        (lk_pc),
  .xl_paddr     (xl_paddr),
  .xl_hit       (xl_hit),
  .xl_miss      (xl_miss),
  .trap_pending (trap_pending),
  .trap_vaddr   (trap_vaddr),
  .trap_pc      (trap_pc),
  .trap_ack     (trap_ack),
  .sw_inval_all (sw_inval_all),
  .entry_valid  (entry_valid),
  .match_vec    (match_vec)
);

// File: tb/xlat_buf_bench.sv
module xlat_buf_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [1:0]  lk_kind = 2'd0;
  logic [31:0] lk_vaddr = '0;
  logic [31:0] lk_pc = '0;
  logic [31:0] xl_paddr;
  logic        xl_hit, xl_miss, trap_pending;
  logic [31:0] trap_vector, trap_vaddr, trap_pc;
  logic [1:0]  trap_kind;
  logic        trap_ack = 1'b0;
  logic        sw_we = 1'b0, sw_use_victim = 1'b0, sw_inval_all = 1'b0;
  logic [2:0]  sw_index = '0;
  logic [22:0] sw_vpn = '0;
  logic [8:0]  sw_ppn = '0;

  int n_chk = 0;
  int n_fail = 0;

  // Bench-side table model
  bit         m_valid [8];
  logic [22:0] m_vpn [8];
  logic [8:0]  m_ppn [8];
  int          m_vic = 0;
  bit          m_pend = 0;

  always #4 clk = ~clk;

  xlat_buf u_xlat_buf (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_kind(lk_kind),
    .lk_vaddr(lk_vaddr), .lk_pc(lk_pc), .xl_paddr(xl_paddr), .xl_hit(xl_hit),
    .xl_miss(xl_miss), .trap_pending(trap_pending), .trap_vector(trap_vector),
    .trap_vaddr(trap_vaddr), .trap_pc(trap_pc), .trap_kind(trap_kind),
    .trap_ack(trap_ack), .sw_we(sw_we), .sw_use_victim(sw_use_victim),
    .sw_index(sw_index), .sw_vpn(sw_vpn), .sw_ppn(sw_ppn), .sw_inval_all(sw_inval_all)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int find_slot(input logic [22:0] vpn);
    for (int i = 0; i < 8; i++) if (m_valid[i] && m_vpn[i] == vpn) return i;
    return -1;
  endfunction

  task automatic sw_write(input bit vic, input int idx, input logic [22:0] vpn,
                          input logic [8:0] ppn, input bit inval);
    int d, s;
    @(negedge clk);
    sw_we = 1'b1; sw_use_victim = vic; sw_index = 3'(idx);
    sw_vpn = vpn; sw_ppn = ppn; sw_inval_all = inval;
    @(negedge clk);
    sw_we = 1'b0; sw_use_victim = 1'b0; sw_inval_all = 1'b0;
    if (inval) begin
      for (int i = 0; i < 8; i++) m_valid[i] = 0;
      m_vic = 0;
    end else begin
      d = find_slot(vpn);
      s = (d >= 0) ? d : (vic ? m_vic : idx);
      if (d < 0 && vic) m_vic = (m_vic + 1) % 8;
      m_valid[s] = 1; m_vpn[s] = vpn; m_ppn[s] = ppn;
    end
  endtask

  task automatic inval_only();
    @(negedge clk);
    sw_inval_all = 1'b1;
    @(negedge clk);
    sw_inval_all = 1'b0;
    for (int i = 0; i < 8; i++) m_valid[i] = 0;
    m_vic = 0;
  endtask

  // Present one lookup, check same-cycle result, then the registered trap.
  task automatic look(input logic [31:0] va, input logic [1:0] kind,
                      input logic [31:0] pc, input string req);
    bit act, ext, e_hit, e_miss;
    int s;
    logic [31:0] e_pa, old_va, old_pc;
    old_va = trap_vaddr; old_pc = trap_pc;
    @(negedge clk);
    lk_valid = 1'b1; lk_kind = kind; lk_vaddr = va; lk_pc = pc;
    #1;
    act = (kind != 2'd0) && !m_pend;
    ext = (va >= 32'h0004_0000);
    s = find_slot(va[31:9]);
    e_hit = act && (!ext || s >= 0);
    e_miss = act && ext && s < 0;
    e_pa = !ext ? va : {14'b0, (s >= 0 ? m_ppn[s] : 9'd0), va[8:0]};
    chk(xl_hit == e_hit, {req, " hit"}, 32'(xl_hit), 32'(e_hit));
    chk(xl_miss == e_miss, {req, " miss"}, 32'(xl_miss), 32'(e_miss));
    if (e_hit) chk(xl_paddr == e_pa, {req, " paddr"}, xl_paddr, e_pa);
    @(negedge clk);
    lk_valid = 1'b0; lk_kind = 2'd0;
    #1;
    if (e_miss) begin
      m_pend = 1;
      chk(trap_pending == 1'b1, "R4 trap raised", 32'(trap_pending), 32'd1);
      chk(trap_vector == 32'h100, "R4 handler vector", trap_vector, 32'h100);
      chk(trap_vaddr == va, "R5 fault vaddr", trap_vaddr, va);
      chk(trap_pc == pc, "R5 fault pc", trap_pc, pc);
      chk(trap_kind == kind, "R5 fault kind", 32'(trap_kind), 32'(kind));
    end else if (m_pend) begin
      chk(trap_vaddr == old_va && trap_pc == old_pc, "R7 capture unchanged",
          trap_pc, old_pc);
    end
  endtask

  task automatic ack();
    @(negedge clk);
    chk(trap_pending == 1'b1, "R6 still pending before ack", 32'(trap_pending), 32'd1);
    trap_ack = 1'b1;
    @(negedge clk);
    trap_ack = 1'b0;
    m_pend = 0;
    chk(trap_pending == 1'b0, "R6 cleared after ack", 32'(trap_pending), 32'd0);
    chk(trap_vector == 32'h0, "R4 vector idle", trap_vector, 32'h0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_valid[i] = 0; m_vpn[i] = '0; m_ppn[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R12 reset state
    chk(trap_pending == 1'b0, "R12 no trap after reset", 32'(trap_pending), 32'd0);
    chk(!xl_hit && !xl_miss, "R2 idle outputs", 32'({xl_hit, xl_miss}), 32'd0);
    look(32'h0010_0000, 2'd1, 32'h0000_2000, "R12 empty table misses");
    ack();

    // R1 bypass sweep, including the top of the local window
    for (int k = 1; k < 4; k++) begin
      look(32'h0000_0000, 2'(k), 32'h10, "R1 bypass low");
      look(32'h0003_FFFF, 2'(k), 32'h14, "R1 bypass top");
      look(32'h0001_2345 + 32'(k), 2'(k), 32'h18, "R1 bypass mid");
    end
    // R2 kind 0 and valid low do nothing
    look(32'h0050_0000, 2'd0, 32'h20, "R2 kind none");
    @(negedge clk); lk_vaddr = 32'h0050_0000; lk_kind = 2'd2; #1;
    chk(!xl_hit && !xl_miss, "R2 valid low", 32'({xl_hit, xl_miss}), 32'd0);
    lk_kind = 2'd0;

    // R4/R5/R7: miss at the window boundary, then ignored lookups
    look(32'h0004_0000, 2'd3, 32'h0000_3000, "R4 boundary miss");
    look(32'h0004_0200, 2'd2, 32'h0000_3004, "R7 ignored miss");
    look(32'h0000_0100, 2'd1, 32'h0000_3008, "R7 ignored bypass");
    ack();

    // R8 indexed fill of every slot, swept at both page edges
    for (int i = 0; i < 8; i++)
      sw_write(0, i, 23'h0800 + 23'(i * 3), 9'h40 + 9'(i * 37), 0);
    for (int i = 0; i < 8; i++) begin
      look({23'h0800 + 23'(i * 3), 9'h000}, 2'(1 + i % 3), 32'h40, "R3 R8 hit offset 0");
      look({23'h0800 + 23'(i * 3), 9'h1FF}, 2'(1 + (i + 1) % 3), 32'h44, "R3 R8 hit offset 511");
    end
    look({23'h0801, 9'h005}, 2'd2, 32'h0000_4444, "R3 unmapped neighbour misses");
    ack();

    // R11 invalidate-all wins over a simultaneous write
    sw_write(0, 2, 23'h0999, 9'h011, 1);
    look({23'h0800, 9'h000}, 2'd1, 32'h50, "R11 cleared entry misses");
    ack();
    look({23'h0999, 9'h000}, 2'd1, 32'h54, "R11 dropped write misses");
    ack();

    // R9 round-robin victim with wrap
    for (int i = 0; i < 9; i++) sw_write(1, 0, 23'h1000 + 23'(i), 9'h100 + 9'(i), 0);
    look({23'h1000, 9'h010}, 2'd2, 32'h60, "R9 wrapped victim evicted slot 0");
    ack();
    look({23'h1008, 9'h010}, 2'd2, 32'h64, "R9 wrapped write present");
    look({23'h1001, 9'h010}, 2'd3, 32'h68, "R9 slot 1 intact");

    // R10 duplicate page merges and does not advance the victim
    sw_write(0, 5, 23'h1003, 9'h0AA, 0);
    look({23'h1003, 9'h123}, 2'd2, 32'h70, "R10 merged new ppn");
    look({23'h1005, 9'h123}, 2'd2, 32'h74, "R10 selected slot untouched");
    sw_write(1, 0, 23'h1003, 9'h0BB, 0);
    sw_write(1, 0, 23'h1100, 9'h0CC, 0);
    look({23'h1001, 9'h000}, 2'd1, 32'h78, "R10 victim stayed at slot 1");
    ack();
    look({23'h1002, 9'h000}, 2'd1, 32'h7C, "R10 slot 2 intact");
    look({23'h1100, 9'h1FE}, 2'd1, 32'h80, "R10 victim write present");
    look({23'h1003, 9'h001}, 2'd3, 32'h84, "R10 second merge");

    // R11 victim resets to 0
    inval_only();
    sw_write(1, 0, 23'h2000, 9'h077, 0);
    sw_write(0, 0, 23'h2001, 9'h078, 0);
    look({23'h2000, 9'h000}, 2'd1, 32'h90, "R11 victim restarted at slot 0");
    ack();
    look({23'h2001, 9'h0F0}, 2'd1, 32'h94, "R11 indexed overwrite of slot 0");

    summary();
    $finish;
  end
endmodule